// File: doc/BRIEF.md
# Framebuffer Control and Status Registers with Vertical-Sync Interrupt

This block is the small register file that sits beside a framebuffer's pixel engine. Software reaches it through a 32-byte window addressed by a 5-bit offset. Only the upper half of the window is decoded. The block holds four kinds of register:

- a control byte whose top bit arms the vertical-sync interrupt;
- a status byte that merges a sticky interrupt-pending flag with fixed board-identification bits;
- a bank of general-purpose bytes;
- a lower half of the window that is inert.

The display side sends a single-cycle end-of-frame strobe. When the interrupt is armed, that strobe latches the pending flag, and the flag drives the interrupt line directly. Software acknowledges the interrupt by writing the status offset. The value written plays no part.

Register access is a plain single-cycle strobe interface with no back-pressure. A write takes effect at the clock edge where `wr_en` is high. A read returns its data one cycle after `rd_en`, flagged by `rd_valid`. A read and a write in the same cycle use the same offset. The read returns the contents as they were before that edge.

Top module: `fbc_ctlstat_regs`

## Requirements
- R1: After reset the interrupt line is low, the control byte reads 0x00, the status byte reads 0x61, and every general byte reads 0x00.
- R2: Offset 0x10 is the control byte. It reads back the full byte last written to it. Bit 7 is the interrupt arm bit.
- R3: When `frame_end` is high at a clock edge and control bit 7 is set, the pending flag and `irq` are high from that edge on.
- R4: When control bit 7 is clear, `frame_end` leaves `irq` and the pending flag unchanged.
- R5: Any write to offset 0x11 clears the pending flag and drops `irq` at that edge, whatever the data byte is.
- R6: A read of offset 0x11 returns bits 6:5 = 11 and bit 0 = 1 at all times, bit 7 = the pending flag, and zero elsewhere. The data written to 0x11 is never stored.
- R7: Offsets 0x12 to 0x1F are fourteen independent bytes. Each reads back the last value written to it.
- R8: Offsets 0x00 to 0x0F read as 0x00. Writes to them change no register.
- R9: If `frame_end` with the arm bit set and a status write fall on the same edge, the pending flag ends set.
- R10: The pending flag stays set until a status write, even if the arm bit is cleared afterwards.
- R11: `rd_valid` is high exactly in the cycle after a cycle with `rd_en` high. `rd_data` then holds the addressed value as it was at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_addr | input | 5 | Byte offset within the register window |
| wr_en | input | 1 | Write strobe for the addressed byte |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe for the addressed byte |
| rd_data | output | 8 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| frame_end | input | 1 | End-of-frame strobe from the display side |
| irq | output | 1 | Vertical-sync interrupt, level, high while pending |

## Verification
The bench builds the block with its default widths: a 5-bit offset and 8-bit data. With these widths the whole window is reachable, so every one of the 32 offsets is written and read. This covers both edges of the general bank and the full inert lower half. Coincident frame-end and acknowledge strobes are driven on the same edge to check that the set takes priority. A status write with an all-ones byte checks that the ID bits and the unused bits never latch data.

// File: rtl/fbc_regs_pkg.sv
package fbc_regs_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] OFF_CTRL   = 5'h10;
  localparam logic [ADDR_W-1:0] OFF_STAT   = 5'h11;
  localparam logic [ADDR_W-1:0] OFF_GP_LO  = 5'h12;
  localparam logic [ADDR_W-1:0] OFF_GP_HI  = 5'h1F;

  localparam int GP_COUNT = int'(OFF_GP_HI) - int'(OFF_GP_LO) + 1;
  localparam int GP_IDX_W = $clog2(GP_COUNT);

  localparam int ARM_BIT  = 7;
  localparam int PEND_BIT = 7;

  // fixed identification bits merged into every status read
  localparam logic [DATA_W-1:0] STAT_ID_BITS = 8'h61;
endpackage

// File: rtl/fbc_addr_decode.sv
module fbc_addr_decode
  import fbc_regs_pkg::*;
#(
  parameter int AW  = ADDR_W,
  parameter int NGP = GP_COUNT,
  parameter int IW  = GP_IDX_W
) (
  input  logic [AW-1:0] addr,
  output logic          hit_ctrl,
  output logic          hit_stat,
  output logic          hit_gp,
  output logic [IW-1:0] gp_idx
);
  localparam logic [AW-1:0] NGP_V = AW'(NGP);

  logic [AW-1:0] gp_off;

  always_comb begin
    gp_off   = addr - OFF_GP_LO;
    hit_ctrl = (addr == OFF_CTRL);
    hit_stat = (addr == OFF_STAT);
    hit_gp   = (addr >= OFF_GP_LO) && (gp_off < NGP_V);
    gp_idx   = gp_off[IW-1:0];
  end
endmodule

// File: rtl/fbc_gp_bank.sv
module fbc_gp_bank #(
  parameter int DW  = 8,
  parameter int NGP = 14,
  parameter int IW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_byte
);
  logic [NGP-1:0][DW-1:0] cells;

  for (genvar g = 0; g < NGP; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n)
        cells[g] <= '0;
      else if (wr_en && (wr_idx == IW'(g)))
        cells[g] <= wr_data;
    end
  end

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < NGP; i++)
      if (rd_idx == IW'(i)) rd_byte = cells[i];
  end
endmodule

// File: rtl/fbc_vsync_irq.sv
module fbc_vsync_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_end,
  input  logic armed,
  input  logic ack,
  output logic pending
);
  logic set_now;

  always_comb set_now = frame_end && armed;

  // set has priority over acknowledge so no frame event is dropped
  always_ff @(posedge clk) begin
    if (!rst_n)       pending <= 1'b0;
    else if (set_now) pending <= 1'b1;
    else if (ack)     pending <= 1'b0;
  end
endmodule

// File: rtl/fbc_ctlstat_regs.sv
module fbc_ctlstat_regs
  import fbc_regs_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] acc_addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  input  logic          frame_end,
  output logic          irq
);
  localparam int NGP = GP_COUNT;
  localparam int IW  = GP_IDX_W;

  logic          hit_ctrl, hit_stat, hit_gp;
  logic [IW-1:0] gp_idx;
  logic [DW-1:0] ctrl_q;
  logic [DW-1:0] gp_byte;
  logic [DW-1:0] stat_view;
  logic [DW-1:0] rd_mux;
  logic          pending;

  fbc_addr_decode #(.AW(AW), .NGP(NGP), .IW(IW)) u_dec (
    .addr     (acc_addr),
    .hit_ctrl (hit_ctrl),
    .hit_stat (hit_stat),
    .hit_gp   (hit_gp),
    .gp_idx   (gp_idx)
  );

  fbc_gp_bank #(.DW(DW), .NGP(NGP), .IW(IW)) u_gp (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en && hit_gp),
    .wr_idx  (gp_idx),
    .wr_data (wr_data),
    .rd_idx  (gp_idx),
    .rd_byte (gp_byte)
  );

  fbc_vsync_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_end (frame_end),
    .armed     (ctrl_q[ARM_BIT]),
    .ack       (wr_en && hit_stat),
    .pending   (pending)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                  ctrl_q <= '0;
    else if (wr_en && hit_ctrl)  ctrl_q <= wr_data;
  end

  always_comb begin
    stat_view           = DW'(STAT_ID_BITS);
    stat_view[PEND_BIT] = pending;
  end

  always_comb begin
    if (hit_ctrl)      rd_mux = ctrl_q;
    else if (hit_stat) rd_mux = stat_view;
    else if (hit_gp)   rd_mux = gp_byte;
    else               rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end

  assign irq = pending;
endmodule

// File: rtl/fbc_ctlstat_checker.sv
module fbc_ctlstat_checker
  import fbc_regs_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  acc_addr,
  input logic        wr_en,
  input logic        rd_en,
  input logic [7:0]  rd_data,
  input logic        rd_valid,
  input logic        frame_end,
  input logic        irq,
  input logic [7:0]  ctrl_q
);
  logic set_ev, ack_ev;
  assign set_ev = frame_end && ctrl_q[ARM_BIT];
  assign ack_ev = wr_en && (acc_addr == OFF_STAT);

  AST_SET_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> irq);                                          // R3
  AST_NO_SET_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !set_ev) |=> !irq);                              // R4
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ev && !set_ev) |=> !irq);                            // R5
  AST_SET_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ev && set_ev) |=> irq);                              // R9
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack_ev) |=> irq);                                // R10
  AST_STAT_ID_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && acc_addr == OFF_STAT) |=>
      (rd_data[6:5] == 2'b11 && rd_data[0] && rd_data[4:1] == 4'h0)); // R6
  AST_LOW_HALF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !acc_addr[4]) |=> (rd_data == 8'h00));          // R8
  AST_RD_VALID_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);                                      // R11
  AST_RD_VALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);                                    // R11
endmodule

bind fbc_ctlstat_regs fbc_ctlstat_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_addr  (acc_addr),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .rd_data   (rd_data),
  .rd_valid  (rd_valid),
  .frame_end (frame_end),
  .irq       (irq),
  .ctrl_q    (ctrl_q)
);

// File: tb/fbc_ctlstat_regs_bench.sv
module fbc_ctlstat_regs_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] acc_addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       rd_valid;
  logic       frame_end = 1'b0;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fbc_ctlstat_regs u_fbc_ctlstat_regs (
    .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .rd_valid(rd_valid), .frame_end(frame_end), .irq(irq)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk);
    acc_addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    acc_addr = a; rd_en = 1'b1;
    @(posedge clk); #1;
    rd_en = 1'b0;
    chk("R11 rd_valid", {7'b0, rd_valid}, 8'h01);
    d = rd_data;
  endtask

  task automatic pulse_frame();
    @(negedge clk);
    frame_end = 1'b1;
    @(posedge clk); #1;
    frame_end = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 irq", {7'b0, irq}, 8'h00);
    rd(5'h10, d); chk("R1 ctrl", d, 8'h00);
    rd(5'h11, d); chk("R1 status", d, 8'h61);
    for (int i = 8'h12; i <= 8'h1F; i++) begin
      rd(5'(i), d); chk("R1 gp", d, 8'h00);
    end
  endtask

  task automatic t_ctrl();
    logic [7:0] d;
    wr(5'h10, 8'h5A); rd(5'h10, d); chk("R2 ctrl 5A", d, 8'h5A);
    wr(5'h10, 8'hA5); rd(5'h10, d); chk("R2 ctrl A5", d, 8'hA5);
    wr(5'h10, 8'h00);
  endtask

  task automatic t_unarmed();
    logic [7:0] d;
    pulse_frame();
    chk("R4 irq", {7'b0, irq}, 8'h00);
    rd(5'h11, d); chk("R4 status", d, 8'h61);
  endtask

  task automatic t_set_ack();
    logic [7:0] d;
    wr(5'h10, 8'h80);
    pulse_frame();
    chk("R3 irq", {7'b0, irq}, 8'h01);
    rd(5'h11, d); chk("R6 status pending", d, 8'hE1);
    wr(5'h11, 8'h00);
    chk("R5 irq after ack 00", {7'b0, irq}, 8'h00);
    pulse_frame();
    wr(5'h11, 8'h80);
    chk("R5 irq after ack 80", {7'b0, irq}, 8'h00);
    wr(5'h11, 8'hFF);
    rd(5'h11, d); chk("R6 status ignores data", d, 8'h61);
  endtask

  task automatic t_sticky();
    logic [7:0] d;
    pulse_frame();
    wr(5'h10, 8'h00);
    repeat (3) @(posedge clk);
    #1 chk("R10 sticky", {7'b0, irq}, 8'h01);
    rd(5'h11, d); chk("R10 status", d, 8'hE1);
    wr(5'h11, 8'h00);
    chk("R10 ack", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_collide();
    wr(5'h10, 8'h80);
    @(negedge clk);
    acc_addr = 5'h11; wr_data = 8'h00; wr_en = 1'b1; frame_end = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0; frame_end = 1'b0;
    chk("R9 set wins", {7'b0, irq}, 8'h01);
    wr(5'h11, 8'h00);
    wr(5'h10, 8'h00);
  endtask

  task automatic t_gp();
    logic [7:0] d;
    for (int i = 8'h12; i <= 8'h1F; i++) wr(5'(i), 8'(i * 7 + 3));
    for (int i = 8'h12; i <= 8'h1F; i++) begin
      rd(5'(i), d); chk("R7 gp", d, 8'(i * 7 + 3));
    end
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    for (int i = 0; i < 16; i++) wr(5'(i), 8'hFF);
    for (int i = 0; i < 16; i++) begin
      rd(5'(i), d); chk("R8 low half", d, 8'h00);
    end
    rd(5'h10, d); chk("R8 ctrl untouched", d, 8'h00);
    rd(5'h12, d); chk("R8 gp lo untouched", d, 8'(8'h12 * 7 + 3));
    rd(5'h1F, d); chk("R8 gp hi untouched", d, 8'(8'h1F * 7 + 3));
    chk("R8 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_rdvalid_idle();
    @(negedge clk);
    @(posedge clk); #1;
    chk("R11 idle rd_valid", {7'b0, rd_valid}, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_ctrl();
    t_unarmed();
    t_set_ack();
    t_sticky();
    t_collide();
    t_gp();
    t_unmapped();
    t_rdvalid_idle();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule